// File: doc/BRIEF.md
# CVSD Calibration Pattern Source and Run-of-Three Duty Monitor

This block serves as test equipment for a continuously variable slope delta decoder. It emits one of four fixed bit sequences, one bit for each bit-rate strobe. Two of the sequences are for the 16 kbps rate and two are for the 32 kbps rate. At each rate, one sequence has no runs of three like bits, which sets the level 24 dB below the reference. The other sequence has such runs about 30 % of the time, which sets the 0 dBm0 reference level. A two-bit select input chooses the sequence. A new selection is applied only after the last bit of the sequence now being sent, so a partial sequence never appears on the output. A sticky flag records that a different sequence has been applied.

The same block holds a monitor for the slope-overload condition. It watches a separate serial input, which is usually an encoder output or this block's own output looped back. On each strobe it decides whether the bit just sampled, together with the two bits before it, forms three like bits. It counts these decisions over a window of 2^N strobes. At the end of the window it latches both the overload count and the window length, and it pulses a done output. Software or a test harness then compares the ratio with the expected duty, for example 0.30 for a reference-level tone.

Top module: `cvsd_ref_top`

## Requirements
- R1: After a synchronous reset, the block selects pattern 0 at its first bit, so `ref_bit` is 1. `pat_changed`, `ovl_flag`, `win_done`, `ovl_count` and `win_total` are all 0.
- R2: `pat_sel` chooses the pattern as follows. Code 0 is the 20-bit word 0xDB492, code 1 is the 40-bit word 0xDB54924AB6, code 2 is the 20-bit word 0xFB412 and code 3 is the 40-bit word 0xFDAA10255E. Each word is sent most significant bit first and repeats without a gap.
- R3: `ref_bit` moves to the next bit only in the cycle after a cycle in which `bit_stb` is high. Otherwise it holds its value.
- R4: A change of `pat_sel` takes effect only at the strobe that consumes the last bit of the current repetition. The new pattern then starts at its first bit.
- R5: `pat_changed` goes to 1 when a boundary applies a selection that differs from the pattern in use. It stays at 1 until reset. A boundary that keeps the same selection does not set it.
- R6: On a strobe where the sampled `mon_bit` equals each of the two previously sampled bits, the overload decision is true. `ovl_flag` shows the decision for the latest strobe and holds it until the next strobe. No decision is true until at least two bits have been sampled since reset.
- R7: A window spans 2^N strobes. At its end, `ovl_count` receives the number of strobes in the window whose overload decision was true, and `win_total` receives 2^N. Both outputs hold until the next window ends.
- R8: `win_done` is high for exactly the one cycle after the final strobe of a window. The two count outputs change in that same cycle.
- R9: N is taken from `win_log2` at reset and at the end of each window. A value above MAX_LOG2 (default 12) is treated as MAX_LOG2.
- R10: The monitor depends only on `mon_bit` and `bit_stb`. It gives the same results whether `mon_bit` comes from `ref_bit` or from an external stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_stb | input | 1 | One-cycle bit-rate strobe |
| pat_sel | input | 2 | Requested pattern code |
| win_log2 | input | LOG2_W (4) | Window exponent N |
| mon_bit | input | 1 | Serial stream under measurement |
| ref_bit | output | 1 | Current pattern bit |
| pat_changed | output | 1 | Sticky flag: a different pattern was applied |
| ovl_flag | output | 1 | Overload decision of the latest strobe |
| win_done | output | 1 | One-cycle end-of-window pulse |
| ovl_count | output | CW (13) | Overload strobes counted in the last window |
| win_total | output | CW (13) | Strobes in the last window |

## Verification
The assertions assume that `bit_stb` is a clean single-cycle qualifier. Because of this, every change of `ref_bit` or `ovl_flag` can be traced to a strobe in the previous cycle, and every done pulse follows a strobe. They also assume that `win_log2` is applied only through the clamp, which gives a window total with a single bit set. The stimulus holds `pat_sel`, `win_log2` and `mon_bit` steady across each clock edge by driving them on the falling edge. It uses strobe spacings of one, two and three cycles. It changes the selection and the window exponent in the middle of a repetition and in the middle of a window, which exercises the deferred application.

// File: rtl/cvsd_ref_pkg.sv
// Shared constants and helpers for the CVSD calibration pattern block.
// Assumes: pattern words are right-aligned in a PAT_W-bit vector and are
// sent most significant bit first.
package cvsd_ref_pkg;

    localparam int PAT_W = 40;
    localparam int IDX_W = $clog2(PAT_W);

    typedef enum logic [1:0] {
        PAT_16K_LOW = 2'd0,
        PAT_32K_LOW = 2'd1,
        PAT_16K_REF = 2'd2,
        PAT_32K_REF = 2'd3
    } pat_id_e;

    // Returns the right-aligned pattern word for a pattern code.
    function automatic logic [PAT_W-1:0] pat_word(input logic [1:0] id);
        case (pat_id_e'(id))
            PAT_16K_LOW: pat_word = 40'h00000DB492;
            PAT_32K_LOW: pat_word = 40'hDB54924AB6;
            PAT_16K_REF: pat_word = 40'h00000FB412;
            default:     pat_word = 40'hFDAA10255E;
        endcase
    endfunction

    // Returns the index of the last bit of the pattern. 16 kbps patterns have 20 bits.
    function automatic logic [IDX_W-1:0] pat_last(input logic [1:0] id);
        pat_last = id[0] ? IDX_W'(PAT_W - 1) : IDX_W'(PAT_W / 2 - 1);
    endfunction

endpackage

// File: rtl/cvsd_pat_gen.sv
// Serial pattern source. It presents the current bit of the active pattern
// and advances one bit on each strobe. The requested code is adopted only
// when the last bit of a repetition is consumed.
// Assumes: stb is a single-cycle qualifier and sel_req is stable at the clock edge.
module cvsd_pat_gen
    import cvsd_ref_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb,
    input  logic [1:0] sel_req,
    output logic       bit_o,
    output logic       applied_o
);

    logic [1:0]       cur_sel;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] pos;
    logic [PAT_W-1:0] word;

    // Selects the bit of the active word that sits at the current position.
    always_comb begin
        last_idx = pat_last(cur_sel);
        word     = pat_word(cur_sel);
        pos      = last_idx - idx;
        bit_o    = word[pos];
    end

    // Advances the position and, at the boundary, adopts the requested pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sel   <= 2'd0;
            idx       <= '0;
            applied_o <= 1'b0;
        end else if (stb) begin
            if (idx == last_idx) begin
                idx     <= '0;
                cur_sel <= sel_req;
                if (sel_req != cur_sel) applied_o <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cvsd_run3_det.sv
// Run-of-three detector. On a strobe, the sampled bit and the two bits
// sampled before it are compared. The decision is available at once for
// counting, and it is also registered and held until the next strobe.
// Assumes: no decision is made until two bits have been sampled since reset.
module cvsd_run3_det (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic bit_i,
    output logic hit_now,
    output logic hit_q
);

    logic [1:0] hist;
    logic [1:0] fill;

    // Decision for the bit being sampled at this strobe.
    always_comb hit_now = (fill == 2'd2) && (bit_i == hist[0]) && (bit_i == hist[1]);

    // Shifts the history, counts how many bits have been seen, and holds the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist  <= 2'b00;
            fill  <= 2'd0;
            hit_q <= 1'b0;
        end else if (stb) begin
            hist  <= {hist[0], bit_i};
            hit_q <= hit_now;
            if (fill != 2'd2) fill <= fill + 1'b1;
        end
    end

endmodule

// File: rtl/cvsd_duty_win.sv
// Windowed duty counter. It counts strobes and true decisions over a window
// of 2^N strobes, then latches both counts and pulses done. N is sampled at
// reset and at each window end, and it is clamped to MAX_LOG2.
// Assumes: stb is a single-cycle qualifier.
module cvsd_duty_win #(
    parameter int MAX_LOG2 = 12,
    parameter int LOG2_W   = $clog2(MAX_LOG2 + 1),
    parameter int CW       = MAX_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              hit,
    input  logic [LOG2_W-1:0] log2_req,
    output logic              done,
    output logic [CW-1:0]     hits_o,
    output logic [CW-1:0]     total_o
);

    logic [LOG2_W-1:0] log2_clamped;
    logic [LOG2_W-1:0] cur_log2;
    logic [CW-1:0]     span;
    logic [CW-1:0]     seen;
    logic [CW-1:0]     acc;
    logic [CW-1:0]     acc_next;

    // Clamps the requested exponent and forms the window span and the next hit total.
    always_comb begin
        log2_clamped = (log2_req > LOG2_W'(MAX_LOG2)) ? LOG2_W'(MAX_LOG2) : log2_req;
        span         = CW'(1) << cur_log2;
        acc_next     = acc + CW'(hit);
    end

    // Accumulates over the window and latches the results at its last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_log2 <= log2_clamped;
            seen     <= '0;
            acc      <= '0;
            done     <= 1'b0;
            hits_o   <= '0;
            total_o  <= '0;
        end else begin
            done <= 1'b0;
            if (stb) begin
                if (seen == span - 1'b1) begin
                    hits_o   <= acc_next;
                    total_o  <= span;
                    done     <= 1'b1;
                    seen     <= '0;
                    acc      <= '0;
                    cur_log2 <= log2_clamped;
                end else begin
                    seen <= seen + 1'b1;
                    acc  <= acc_next;
                end
            end
        end
    end

endmodule

// File: rtl/cvsd_ref_top.sv
// Top of the CVSD calibration block. It holds the pattern source together
// with an independent run-of-three duty monitor on mon_bit.
// Assumes: all inputs are synchronous to clk, and bit_stb is high for one cycle per bit.
module cvsd_ref_top #(
    parameter int MAX_LOG2 = 12,
    parameter int LOG2_W   = $clog2(MAX_LOG2 + 1),
    parameter int CW       = MAX_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic [1:0]        pat_sel,
    input  logic [LOG2_W-1:0] win_log2,
    input  logic              mon_bit,
    output logic              ref_bit,
    output logic              pat_changed,
    output logic              ovl_flag,
    output logic              win_done,
    output logic [CW-1:0]     ovl_count,
    output logic [CW-1:0]     win_total
);

    logic hit_now;

    cvsd_pat_gen u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (bit_stb),
        .sel_req   (pat_sel),
        .bit_o     (ref_bit),
        .applied_o (pat_changed)
    );

    cvsd_run3_det u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (bit_stb),
        .bit_i   (mon_bit),
        .hit_now (hit_now),
        .hit_q   (ovl_flag)
    );

    cvsd_duty_win #(
        .MAX_LOG2 (MAX_LOG2),
        .LOG2_W   (LOG2_W),
        .CW       (CW)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (bit_stb),
        .hit      (hit_now),
        .log2_req (win_log2),
        .done     (win_done),
        .hits_o   (ovl_count),
        .total_o  (win_total)
    );

endmodule

// File: rtl/cvsd_ref_chk.sv
// Property checker for cvsd_ref_top. It is attached by bind and observes the top-level ports only.
module cvsd_ref_chk #(
    parameter int CW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_stb,
    input logic          ref_bit,
    input logic          pat_changed,
    input logic          ovl_flag,
    input logic          win_done,
    input logic [CW-1:0] ovl_count,
    input logic [CW-1:0] win_total
);

    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_stb) |-> $stable(ref_bit));                       // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pat_changed |=> pat_changed);                                 // R5
    AST_OVL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_stb) |-> $stable(ovl_flag));                      // R6
    AST_COUNT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> (ovl_count <= win_total));                       // R7
    AST_DONE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(bit_stb));                                 // R8
    AST_TOTAL_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> ($countones(win_total) == 1));                   // R9

endmodule

bind cvsd_ref_top cvsd_ref_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb     (bit_stb),
    .ref_bit     (ref_bit),
    .pat_changed (pat_changed),
    .ovl_flag    (ovl_flag),
    .win_done    (win_done),
    .ovl_count   (ovl_count),
    .win_total   (win_total)
);

// File: tb/sim_cvsd_ref_top.sv
module sim_cvsd_ref_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXL = 12;
    localparam int LW   = 4;
    localparam int CWB  = 13;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           bit_stb;
    logic [1:0]     pat_sel;
    logic [LW-1:0]  win_log2;
    logic           mon_bit;
    logic           ref_bit, pat_changed, ovl_flag, win_done;
    logic [CWB-1:0] ovl_count, win_total;

    logic   loop_en;
    logic   ext_bit;
    int     ext_mode;
    int     ext_k;
    int     checks = 0;
    int     fails  = 0;
    string  cur_tag = "R2";

    // Model state.
    int m_sel, m_idx, m_chg, m_n, m_h0, m_h1, m_ovl;
    int m_wcnt, m_acc, m_log2, m_cnt, m_tot, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mon_bit = loop_en ? ref_bit : ext_bit;

    cvsd_ref_top u0 (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .pat_sel(pat_sel),
        .win_log2(win_log2), .mon_bit(mon_bit), .ref_bit(ref_bit),
        .pat_changed(pat_changed), .ovl_flag(ovl_flag), .win_done(win_done),
        .ovl_count(ovl_count), .win_total(win_total)
    );

    function automatic int plen(int s);
        return (s % 2 == 1) ? 40 : 20;
    endfunction

    function automatic int pbit(int s, int i);
        logic [39:0] w;
        case (s)
            0: w = 40'hDB492;
            1: w = 40'hDB54924AB6;
            2: w = 40'hFB412;
            default: w = 40'hFDAA10255E;
        endcase
        return int'(w[plen(s) - 1 - i]);
    endfunction

    function automatic int clampl(int v);
        return (v > MAXL) ? MAXL : v;
    endfunction

    function automatic logic ext_val(int mode, int k);
        case (mode)
            1: return 1'b1;
            2: return logic'(k % 2);
            default: return logic'(((k / 3) % 2) ^ ((k % 7) == 0 ? 1 : 0));
        endcase
    endfunction

    // Model: updated on each rising edge from the bench-driven inputs only.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_idx = 0; m_chg = 0; m_n = 0; m_h0 = 0; m_h1 = 0; m_ovl = 0;
            m_wcnt = 0; m_acc = 0; m_cnt = 0; m_tot = 0; m_done = 0;
            m_log2 = clampl(int'(win_log2));
        end else begin
            m_done = 0;
            if (bit_stb) begin
                int b, o;
                b = loop_en ? pbit(m_sel, m_idx) : int'(ext_bit);
                o = (m_n >= 2 && b == m_h0 && b == m_h1) ? 1 : 0;
                m_ovl = o;
                m_h1 = m_h0; m_h0 = b;
                if (m_n < 2) m_n++;
                m_acc += o; m_wcnt++;
                if (m_wcnt == (1 << m_log2)) begin
                    m_cnt = m_acc; m_tot = m_wcnt; m_done = 1;
                    m_acc = 0; m_wcnt = 0; m_log2 = clampl(int'(win_log2));
                end
                if (m_idx == plen(m_sel) - 1) begin
                    m_idx = 0;
                    if (int'(pat_sel) != m_sel) m_chg = 1;
                    m_sel = int'(pat_sel);
                end else begin
                    m_idx++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(ref_bit === logic'(pbit(m_sel, m_idx)), cur_tag, int'(ref_bit), pbit(m_sel, m_idx));
        chk(pat_changed === logic'(m_chg), "R5", int'(pat_changed), m_chg);
        chk(ovl_flag === logic'(m_ovl), "R6", int'(ovl_flag), m_ovl);
        chk(win_done === logic'(m_done), "R8", int'(win_done), m_done);
        chk(ovl_count === CWB'(m_cnt), "R7", int'(ovl_count), m_cnt);
        chk(win_total === CWB'(m_tot), cur_tag, int'(win_total), m_tot);
    endtask

    // Compares on the falling edge, then drives the inputs for the next edge.
    task automatic run(input int cycles, input int period);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare_all();
            bit_stb = (c % period == 0);
            if (bit_stb) begin
                ext_bit = ext_val(ext_mode, ext_k);
                ext_k++;
            end
        end
        @(negedge clk);
        compare_all();
        bit_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 250000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bit_stb = 1'b0; pat_sel = 2'd0; win_log2 = LW'(4);
        loop_en = 1'b1; ext_bit = 1'b0; ext_mode = 1; ext_k = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ref_bit === 1'b1, "R1", int'(ref_bit), 1);
        chk(pat_changed === 1'b0, "R1", int'(pat_changed), 0);
        chk(ovl_flag === 1'b0, "R1", int'(ovl_flag), 0);
        chk(win_done === 1'b0, "R1", int'(win_done), 0);
        chk(ovl_count === '0 && win_total === '0, "R1", int'(ovl_count), 0);
        rst_n = 1'b1;

        cur_tag = "R2"; run(70, 1);          // pattern 0 repeated, same selection
        chk(pat_changed === 1'b0, "R5", int'(pat_changed), 0);
        cur_tag = "R3"; run(90, 3);          // sparse strobes
        cur_tag = "R4"; pat_sel = 2'd1; run(110, 1);
        pat_sel = 2'd2; run(80, 1);
        cur_tag = "R2"; pat_sel = 2'd3; run(170, 2);
        chk(pat_changed === 1'b1, "R5", int'(pat_changed), 1);
        cur_tag = "R9"; win_log2 = LW'(15); run(4300, 1);
        cur_tag = "R7"; win_log2 = LW'(0); run(30, 1);
        win_log2 = LW'(3); run(60, 2);
        cur_tag = "R10"; loop_en = 1'b0;
        ext_mode = 1; run(50, 1);
        ext_mode = 2; run(50, 1);
        ext_mode = 3; run(120, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule